// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit sits beside a small CPU core and watches it run a user program. It holds six 16-bit breakpoint registers. When a programmed breakpoint matches what the core is doing, the unit raises a one-cycle break request and moves its two-bit debug status from background to debug-idle. The host loads the breakpoints only through a dedicated debug-side port. Nothing the CPU does can read or change them.

Breakpoints 0 to 3 always compare against the address of the instruction being executed. Breakpoints 4 and 5 have two uses, chosen by a mode input:
- With the mode input clear, they compare the data memory address of a qualified access.
- With the mode input set, they decode into a module number and a register index. They then match a CPU register write to that destination. The written value can also be checked under a bit mask.

While a prefix instruction is in effect, a match is held pending and the break is issued once the prefixed operation has finished. A host command can force entry into debug mode without any match.

Top module: `bkpt_match_unit`

## Requirements
- R1: After the synchronous reset `rst`, and after any cycle with `tlr` high, all six breakpoint registers hold 16'hFFFF. Reading address k (0 to 5) through the debug port returns breakpoint k on `dbg_rdata` one clock edge after `dbg_addr` is presented.
- R2: A debug write (`dbg_we`) to address 0 to 5 replaces that breakpoint. Writes to addresses 6 and 7 change nothing, and reads of addresses 6 and 7 return 0. CPU register writes (`reg_we`) never alter any breakpoint.
- R3: Breakpoints 0 to 3 match when `inst_done` is high and `pa` equals the stored 16-bit value exactly.
- R4: With `rege` = 0, breakpoints 4 and 5 match when `da_valid` is high and `da` equals the full stored value.
- R5: With `rege` = 1, breakpoints 4 and 5 match when `reg_we` is high, `dst_mod` equals stored bits [3:0] and `dst_idx` equals stored bits [8:4]. Data-address accesses are then ignored by these two breakpoints.
- R6: In register mode, `wdata` must also equal `cmp_data` on every bit where `cmp_mask` is 1. When `cmp_mask` is all zeros, the value written does not matter.
- R7: While `dme` = 0, no breakpoint match produces a break.
- R8: A match seen while `pfx_active` = 1 gives no break while `pfx_active` stays 1. The break is issued on the edge after the first cycle in which `pfx_active` is 0.
- R9: `brk` is a one-cycle pulse on the clock edge that ends the qualifying cycle. On that same edge `dbg_status` changes from 2'b00 (background) to 2'b01 (debug-idle). Once in debug-idle, no further `brk` pulse occurs until reset.
- R10: A `host_cmd` pulse in background mode forces `brk` and debug-idle on the next edge. This happens regardless of `dme`, `pfx_active` and any match.
- R11: A match is judged against the breakpoint value held before the edge. A debug write in the same cycle takes effect for later cycles only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tlr | input | 1 | Test-logic-reset indication; presets all breakpoints |
| dbg_we | input | 1 | Debug-port write strobe |
| dbg_addr | input | 3 | Debug-port breakpoint select |
| dbg_wdata | input | 16 | Debug-port write data |
| dbg_rdata | output | 16 | Registered debug-port read data |
| dme | input | 1 | Breakpoint comparison enable |
| rege | input | 1 | Register-write mode for breakpoints 4 and 5 |
| cmp_mask | input | 16 | Bit mask for register-write data comparison |
| cmp_data | input | 16 | Reference data for register-write comparison |
| inst_done | input | 1 | Instruction at `pa` executes this cycle |
| pa | input | 16 | Program address of the executing instruction |
| da_valid | input | 1 | Data memory access strobe |
| da | input | 16 | Data memory address |
| reg_we | input | 1 | CPU register write strobe |
| dst_mod | input | 4 | Destination module of the register write |
| dst_idx | input | 5 | Destination register index within the module |
| wdata | input | 16 | Value being written to the register |
| pfx_active | input | 1 | A prefix instruction is in effect |
| host_cmd | input | 1 | Host request to enter debug mode |
| brk | output | 1 | Break request pulse |
| dbg_status | output | 2 | 00 background, 01 debug-idle |

## Verification
The host can update a breakpoint in the same cycle that the CPU presents an address the breakpoint is being compared against. The bench provokes this on breakpoint 0 in two ways:
- It writes a new value while the program address equals the new value. This must not break.
- It rewrites the breakpoint away from a value the CPU is hitting in that same cycle. This must break.

A second collision is covered as well. A match and a `host_cmd` can arrive while a prefix is active. The host command must break at once, while the match alone must wait for the prefix to end.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    ST_BACKGROUND = 2'b00,
    ST_DBG_IDLE   = 2'b01
  } dbg_state_e;
endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile #(
  parameter int NUM_BP = 6,
  parameter int W      = 16,
  parameter int SEL_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tlr,
  input  logic                  dbg_we,
  input  logic [SEL_W-1:0]      dbg_addr,
  input  logic [W-1:0]          dbg_wdata,
  output logic [W-1:0]          dbg_rdata,
  output logic [NUM_BP*W-1:0]   bp_flat
);
  logic [W-1:0] bp_q [NUM_BP];
  logic [W-1:0] rd_sel;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    always_ff @(posedge clk) begin
      if (rst || tlr)
        bp_q[g] <= '1;
      else if (dbg_we && dbg_addr == SEL_W'(g))
        bp_q[g] <= dbg_wdata;
    end
    assign bp_flat[g*W +: W] = bp_q[g];
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_BP; i++)
      if (dbg_addr == SEL_W'(i)) rd_sel = bp_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_rdata <= '0;
    else     dbg_rdata <= rd_sel;
  end
endmodule

// File: rtl/bkpt_compare.sv
module bkpt_compare #(
  parameter int NUM_BP    = 6,
  parameter int NUM_PA_BP = 4,
  parameter int W         = 16,
  parameter int DW        = 16,
  parameter int MOD_W     = 4,
  parameter int IDX_W     = 5
) (
  input  logic [NUM_BP*W-1:0] bp_flat,
  input  logic                rege,
  input  logic [DW-1:0]       cmp_mask,
  input  logic [DW-1:0]       cmp_data,
  input  logic                inst_done,
  input  logic [W-1:0]        pa,
  input  logic                da_valid,
  input  logic [W-1:0]        da,
  input  logic                reg_we,
  input  logic [MOD_W-1:0]    dst_mod,
  input  logic [IDX_W-1:0]    dst_idx,
  input  logic [DW-1:0]       wdata,
  output logic [NUM_BP-1:0]   hit
);
  logic data_ok;
  assign data_ok = ((wdata ^ cmp_data) & cmp_mask) == '0;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
    logic [W-1:0] v;
    assign v = bp_flat[g*W +: W];
    if (g < NUM_PA_BP) begin : g_pa
      assign hit[g] = inst_done && (pa == v);
    end else begin : g_dual
      logic da_hit, reg_hit;
      assign da_hit  = da_valid && (da == v);
      assign reg_hit = reg_we && (dst_mod == v[MOD_W-1:0])
                       && (dst_idx == v[MOD_W +: IDX_W]) && data_ok;
      assign hit[g]  = rege ? reg_hit : da_hit;
    end
  end
endmodule

// File: rtl/bkpt_break_ctrl.sv
module bkpt_break_ctrl
  import bkpt_pkg::*;
#(
  parameter int NUM_BP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dme,
  input  logic [NUM_BP-1:0] hit,
  input  logic              pfx_active,
  input  logic              host_cmd,
  output logic              brk,
  output logic [1:0]        dbg_status
);
  dbg_state_e state_q;
  logic pend_q, armed, cand, fire;

  assign armed = dme && (state_q == ST_BACKGROUND);
  assign cand  = armed && ((|hit) || pend_q);
  assign fire  = (cand && !pfx_active) ||
                 (host_cmd && state_q == ST_BACKGROUND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_BACKGROUND;
      pend_q  <= 1'b0;
      brk     <= 1'b0;
    end else begin
      brk <= fire;
      if (fire) state_q <= ST_DBG_IDLE;
      if (!armed || fire) pend_q <= 1'b0;
      else if (cand && pfx_active) pend_q <= 1'b1;
    end
  end

  assign dbg_status = state_q;
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit #(
  parameter int NUM_BP    = 6,
  parameter int NUM_PA_BP = 4,
  parameter int W         = 16,
  parameter int DW        = 16,
  parameter int MOD_W     = 4,
  parameter int IDX_W     = 5,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tlr,
  input  logic             dbg_we,
  input  logic [SEL_W-1:0] dbg_addr,
  input  logic [W-1:0]     dbg_wdata,
  output logic [W-1:0]     dbg_rdata,
  input  logic             dme,
  input  logic             rege,
  input  logic [DW-1:0]    cmp_mask,
  input  logic [DW-1:0]    cmp_data,
  input  logic             inst_done,
  input  logic [W-1:0]     pa,
  input  logic             da_valid,
  input  logic [W-1:0]     da,
  input  logic             reg_we,
  input  logic [MOD_W-1:0] dst_mod,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [DW-1:0]    wdata,
  input  logic             pfx_active,
  input  logic             host_cmd,
  output logic             brk,
  output logic [1:0]       dbg_status
);
  logic [NUM_BP*W-1:0] bp_flat;
  logic [NUM_BP-1:0]   hit;

  bkpt_regfile #(.NUM_BP(NUM_BP), .W(W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .tlr(tlr), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .bp_flat(bp_flat)
  );

  bkpt_compare #(.NUM_BP(NUM_BP), .NUM_PA_BP(NUM_PA_BP), .W(W), .DW(DW),
                 .MOD_W(MOD_W), .IDX_W(IDX_W)) u_cmp (
    .bp_flat(bp_flat), .rege(rege), .cmp_mask(cmp_mask), .cmp_data(cmp_data),
    .inst_done(inst_done), .pa(pa), .da_valid(da_valid), .da(da),
    .reg_we(reg_we), .dst_mod(dst_mod), .dst_idx(dst_idx), .wdata(wdata),
    .hit(hit)
  );

  bkpt_break_ctrl #(.NUM_BP(NUM_BP)) u_ctrl (
    .clk(clk), .rst(rst), .dme(dme), .hit(hit), .pfx_active(pfx_active),
    .host_cmd(host_cmd), .brk(brk), .dbg_status(dbg_status)
  );
endmodule

// File: rtl/bkpt_checker.sv
module bkpt_checker #(
  parameter int NUM_BP = 6,
  parameter int W      = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                tlr,
  input logic                dme,
  input logic                host_cmd,
  input logic                pfx_active,
  input logic                brk,
  input logic [1:0]          dbg_status,
  input logic [NUM_BP*W-1:0] bp_flat
);
  // R1: test-logic-reset presets every breakpoint
  a_r1_tlr_preset: assert property (@(posedge clk) disable iff (rst)
    tlr |=> (bp_flat == {NUM_BP*W{1'b1}}));

  // R7: disabled comparison gives no break without a host command
  a_r7_dme_off: assert property (@(posedge clk) disable iff (rst)
    (!dme && !host_cmd) |=> !brk);

  // R8: no break from a match while a prefix is in effect
  a_r8_pfx_hold: assert property (@(posedge clk) disable iff (rst)
    (pfx_active && !host_cmd) |=> !brk);

  // R9: single-cycle pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    brk |=> !brk);

  // R9: status enters debug-idle together with the pulse
  a_r9_status_with_brk: assert property (@(posedge clk) disable iff (rst)
    brk |-> (dbg_status == 2'b01));

  // R9: debug-idle is only entered through a break
  a_r9_rise_needs_brk: assert property (@(posedge clk) disable iff (rst)
    $rose(dbg_status[0]) |-> brk);

  // R9: no further pulse once in debug-idle
  a_r9_quiet_in_debug: assert property (@(posedge clk) disable iff (rst)
    (dbg_status == 2'b01) |=> !brk);
endmodule

bind bkpt_match_unit bkpt_checker #(.NUM_BP(NUM_BP), .W(W)) u_chk (
  .clk(clk), .rst(rst), .tlr(tlr), .dme(dme), .host_cmd(host_cmd),
  .pfx_active(pfx_active), .brk(brk), .dbg_status(dbg_status),
  .bp_flat(bp_flat)
);

// File: tb/tb_bkpt_match_unit.sv
module tb_bkpt_match_unit;
  logic clk = 0, rst = 1, tlr = 0;
  logic dbg_we = 0;
  logic [2:0] dbg_addr = 0;
  logic [15:0] dbg_wdata = 0, dbg_rdata;
  logic dme = 0, rege = 0;
  logic [15:0] cmp_mask = 0, cmp_data = 0;
  logic inst_done = 0, da_valid = 0, reg_we = 0, pfx_active = 0, host_cmd = 0;
  logic [15:0] pa = 0, da = 0, wdata = 0;
  logic [3:0] dst_mod = 0;
  logic [4:0] dst_idx = 0;
  logic brk;
  logic [1:0] dbg_status;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  bkpt_match_unit dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; dme = 0; rege = 0; cmp_mask = 0; cmp_data = 0;
    inst_done = 0; da_valid = 0; reg_we = 0; pfx_active = 0; host_cmd = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic bp_write(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk);
    dbg_we = 1; dbg_addr = a; dbg_wdata = v;
    @(negedge clk);
    dbg_we = 0;
  endtask

  task automatic bp_read(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    dbg_addr = a;
    @(negedge clk);
    v = dbg_rdata;
  endtask

  // ends one stimulus cycle; checks brk after the edge and its fall one cycle later
  task automatic end_cycle(input bit exp_brk, input string tag);
    @(negedge clk);
    inst_done = 0; da_valid = 0; reg_we = 0; host_cmd = 0; dbg_we = 0;
    chk(brk == exp_brk, tag, brk, exp_brk);
    if (exp_brk) begin
      chk(dbg_status == 2'b01, {tag, " status"}, dbg_status, 1);
      @(negedge clk);
      chk(brk == 0, {tag, " pulse width"}, brk, 0);
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    chk(brk == 0 && dbg_status == 2'b00, "R1 reset outputs", {brk, dbg_status}, 0);
    for (int k = 0; k < 6; k++) begin
      bp_read(3'(k), v);
      chk(v == 16'hFFFF, "R1 reset value", v, 16'hFFFF);
    end
  endtask

  task automatic t_write_read();
    logic [15:0] v;
    do_reset();
    for (int k = 0; k < 6; k++) bp_write(3'(k), 16'h0100 + 16'(k) * 16'h0011);
    bp_write(3'd6, 16'h5555);
    for (int k = 0; k < 6; k++) begin
      bp_read(3'(k), v);
      chk(v == 16'h0100 + 16'(k) * 16'h0011, "R2 readback", v, 16'h0100 + k * 16'h11);
    end
    bp_read(3'd6, v);
    chk(v == 0, "R2 unused address", v, 0);
    @(negedge clk);
    reg_we = 1; dst_mod = 4'h1; dst_idx = 5'h2; wdata = 16'hDEAD;
    @(negedge clk);
    reg_we = 0;
    bp_read(3'd4, v);
    chk(v == 16'h0144, "R2 cpu write ignored", v, 16'h0144);
  endtask

  task automatic t_tlr();
    logic [15:0] v;
    do_reset();
    bp_write(3'd3, 16'h1111);
    @(negedge clk); tlr = 1;
    @(negedge clk); tlr = 0;
    bp_read(3'd3, v);
    chk(v == 16'hFFFF, "R1 tlr preset", v, 16'hFFFF);
  endtask

  task automatic t_pa();
    do_reset();
    bp_write(3'd2, 16'h1234);
    dme = 1;
    @(negedge clk); inst_done = 1; pa = 16'h1233;
    end_cycle(0, "R3 near miss");
    @(negedge clk); inst_done = 1; pa = 16'h1234;
    end_cycle(1, "R3 R9 program address hit");
    @(negedge clk); inst_done = 1; pa = 16'h1234;
    end_cycle(0, "R9 suppressed in debug");
  endtask

  task automatic t_da();
    do_reset();
    bp_write(3'd4, 16'h0040);
    dme = 1; rege = 0;
    @(negedge clk); da_valid = 0; da = 16'h0040;
    end_cycle(0, "R4 no strobe");
    @(negedge clk); da_valid = 1; da = 16'h0040;
    end_cycle(1, "R4 data address hit");
  endtask

  task automatic t_reg();
    do_reset();
    bp_write(3'd5, 16'h0037);  // idx 3 in [8:4], module 7 in [3:0]
    dme = 1; rege = 1; cmp_mask = 0;
    @(negedge clk); da_valid = 1; da = 16'h0037;
    end_cycle(0, "R5 data address ignored");
    @(negedge clk); reg_we = 1; dst_mod = 4'h7; dst_idx = 5'h4; wdata = 16'h9999;
    end_cycle(0, "R5 wrong index");
    @(negedge clk); reg_we = 1; dst_mod = 4'h7; dst_idx = 5'h3; wdata = 16'h9999;
    end_cycle(1, "R5 R6 register hit, zero mask");
  endtask

  task automatic t_mask();
    do_reset();
    bp_write(3'd4, 16'h0015);  // idx 1, module 5
    dme = 1; rege = 1; cmp_mask = 16'h00F0; cmp_data = 16'h00A0;
    @(negedge clk); reg_we = 1; dst_mod = 4'h5; dst_idx = 5'h1; wdata = 16'h12B0;
    end_cycle(0, "R6 masked data miss");
    @(negedge clk); reg_we = 1; dst_mod = 4'h5; dst_idx = 5'h1; wdata = 16'h12A5;
    end_cycle(1, "R6 masked data hit");
  endtask

  task automatic t_dme();
    do_reset();
    bp_write(3'd0, 16'h0200);
    dme = 0;
    @(negedge clk); inst_done = 1; pa = 16'h0200;
    end_cycle(0, "R7 disabled");
    chk(dbg_status == 2'b00, "R7 status", dbg_status, 0);
  endtask

  task automatic t_pfx();
    do_reset();
    bp_write(3'd1, 16'h0300);
    dme = 1;
    @(negedge clk); pfx_active = 1; inst_done = 1; pa = 16'h0300;
    end_cycle(0, "R8 held at match");
    end_cycle(0, "R8 held while prefix");
    @(negedge clk); pfx_active = 0;
    end_cycle(1, "R8 released after prefix");
  endtask

  task automatic t_host();
    do_reset();
    dme = 0;
    @(negedge clk); host_cmd = 1;
    end_cycle(1, "R10 host forced entry");
    do_reset();
    bp_write(3'd1, 16'h0300);
    dme = 1;
    @(negedge clk); pfx_active = 1; inst_done = 1; pa = 16'h0300; host_cmd = 1;
    end_cycle(1, "R10 host during prefix");
    pfx_active = 0;
  endtask

  task automatic t_same();
    do_reset();
    bp_write(3'd0, 16'h1000);
    dme = 1;
    @(negedge clk);
    dbg_we = 1; dbg_addr = 0; dbg_wdata = 16'h2000; inst_done = 1; pa = 16'h2000;
    end_cycle(0, "R11 new value not yet active");
    @(negedge clk); inst_done = 1; pa = 16'h2000;
    end_cycle(1, "R11 new value active next cycle");
    do_reset();
    bp_write(3'd0, 16'h2000);
    dme = 1;
    @(negedge clk);
    dbg_we = 1; dbg_addr = 0; dbg_wdata = 16'h3000; inst_done = 1; pa = 16'h2000;
    end_cycle(1, "R11 old value still compared");
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_tlr();
    t_pa();
    t_da();
    t_reg();
    t_mask();
    t_dme();
    t_pfx();
    t_host();
    t_same();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule